// File: doc/BRIEF.md
# Hot-Insertion Bus Connect Controller

This block is the digital sequencer that decides when two segments of a two-wire open-drain bus may be joined. One segment is the backplane side and the other is the card side. The block watches a supply-good flag from an external undervoltage comparator, an enable input, and the sampled clock and data levels on both sides. It drives a connect strobe to the buffer datapath, an enable for the backplane precharge circuit, and a ready flag.

While the supply is low the block holds off in lockout and keeps precharge on. Once the supply is good and the block is enabled, it waits for a safe moment before joining the segments. A safe moment is either a STOP on the backplane side while the card side is idle, or an unbroken idle time on all four lines. Disabling the block isolates the segments at once. Every later enable, and every return of the supply, starts a fresh wait, so a transfer that is already under way is never passed on half-finished.

The four bus inputs go through two-flop synchronizers. The supply-good and enable inputs are taken as synchronous to the clock.

Top module: `hotplug_connect_ctrl`

## Requirements
- R1: While supply_ok is low, connect and ready are 0 and precharge_en is 1, whatever the bus lines do. In the first cycle after supply_ok returns, connect is still 0.
- R2: precharge_en is 1 whenever connect is 0, and 0 whenever connect is 1. After reset, connect is 0 and precharge_en is 1.
- R3: While the block waits, a STOP joins the segments. A STOP is bp_sda going from 0 to 1 while bp_scl is 1 in both the previous and the current synchronized sample, with cd_scl and cd_sda both 1. If the bp_sda rise is driven between two clock edges, connect is 0 after the second following edge and 1 after the third.
- R4: A STOP seen while cd_scl or cd_sda is 0 does not set connect.
- R5: While the block waits, suppose all four lines are driven high for exactly L consecutive clock edges and then driven low. The segments join if and only if L is at least IDLE_CYCLES. The join takes effect on the IDLE_CYCLES+2'th edge after the lines go high.
- R6: A low level on any single line during the idle wait restarts the idle count from zero. The join then comes IDLE_CYCLES+2 edges after the lines are all high again.
- R7: ready equals connect at all times (1 means released, that is, ready).
- R8: Bringing enable low clears connect at the next clock edge. When enable comes back high with all lines idle, connect stays 0 after IDLE_CYCLES edges and becomes 1 after IDLE_CYCLES+1 edges.
- R9: A fall of supply_ok clears connect within the same cycle, before any clock edge. When supply_ok returns with enable high and the lines idle, connect becomes 1 after IDLE_CYCLES+1 edges and not before.
- R10: While enable is low, neither a STOP nor any idle time sets connect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good flag from the undervoltage comparator |
| enable | input | 1 | 1 allows the segments to be joined |
| bp_scl | input | 1 | Backplane clock level (asynchronous) |
| bp_sda | input | 1 | Backplane data level (asynchronous) |
| cd_scl | input | 1 | Card-side clock level (asynchronous) |
| cd_sda | input | 1 | Card-side data level (asynchronous) |
| connect | output | 1 | Strobe to the buffer datapath: segments joined |
| precharge_en | output | 1 | Backplane precharge enable |
| ready | output | 1 | Ready flag, 1 when the connection is active |

## Verification
A bus-line change is seen two edges later because of the synchronizer. The resulting join appears one edge after that, so it is due three edges after a STOP edge is driven, and IDLE_CYCLES+2 edges after the lines go idle. Enable changes act at the next edge. A fall of supply_ok acts without any edge. The bench drives every input on the falling edge and samples on a falling edge. It checks connect one edge before the due edge and again at the due edge, so an off-by-one in the pipeline or in the counter limit shows up as a failure. Random idle pulses around the limit are scored against the rule that a pulse of L edges joins the segments if and only if L is at least IDLE_CYCLES.

// File: rtl/hic_pkg.sv
package hic_pkg;
  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_OFF  = 2'd1,
    ST_WAIT = 2'd2,
    ST_LINK = 2'd3
  } hic_state_e;

  localparam int unsigned LINES = 4;
  localparam int unsigned L_BP_SCL = 0;
  localparam int unsigned L_BP_SDA = 1;
  localparam int unsigned L_CD_SCL = 2;
  localparam int unsigned L_CD_SDA = 3;
endpackage

// File: rtl/hic_sync2.sv
module hic_sync2 #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= d[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/hic_bus_watch.sv
module hic_bus_watch #(
  parameter int unsigned IDLE_CYCLES = 11875
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [hic_pkg::LINES-1:0] lines,
  input  logic                    clear,
  output logic                    stop_ok,
  output logic                    idle_hit
);
  import hic_pkg::*;

  localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES - 1);

  logic          bp_scl_prev_q;
  logic          bp_sda_prev_q;
  logic          all_high;
  logic          card_idle;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_scl_prev_q <= 1'b0;
      bp_sda_prev_q <= 1'b0;
    end else begin
      bp_scl_prev_q <= lines[L_BP_SCL];
      bp_sda_prev_q <= lines[L_BP_SDA];
    end
  end

  assign all_high  = &lines;
  assign card_idle = lines[L_CD_SCL] & lines[L_CD_SDA];

  // data rises while clock stays high across both samples
  assign stop_ok = lines[L_BP_SCL] & bp_scl_prev_q &
                   lines[L_BP_SDA] & ~bp_sda_prev_q & card_idle;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clear || !all_high) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LIMIT) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign idle_hit = all_high & (cnt_q == LIMIT);
endmodule

// File: rtl/hic_seq.sv
module hic_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic enable,
  input  logic stop_ok,
  input  logic idle_hit,
  output logic waiting,
  output logic linked
);
  import hic_pkg::*;

  hic_state_e state_q;
  hic_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!supply_ok) begin
      state_d = ST_LOCK;
    end else begin
      unique case (state_q)
        ST_LOCK: state_d = enable ? ST_WAIT : ST_OFF;
        ST_OFF:  if (enable) state_d = ST_WAIT;
        ST_WAIT: begin
          if (!enable)                  state_d = ST_OFF;
          else if (stop_ok || idle_hit) state_d = ST_LINK;
        end
        ST_LINK: if (!enable) state_d = ST_OFF;
        default: state_d = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOCK;
    end else begin
      state_q <= state_d;
    end
  end

  assign waiting = (state_q == ST_WAIT);
  assign linked  = (state_q == ST_LINK);
endmodule

// File: rtl/hotplug_connect_ctrl.sv
module hotplug_connect_ctrl #(
  parameter int unsigned IDLE_CYCLES = 11875
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic enable,
  input  logic bp_scl,
  input  logic bp_sda,
  input  logic cd_scl,
  input  logic cd_sda,
  output logic connect,
  output logic precharge_en,
  output logic ready
);
  import hic_pkg::*;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] sync_lines;
  logic             stop_ok;
  logic             idle_hit;
  logic             waiting;
  logic             linked;

  assign raw_lines = {cd_sda, cd_scl, bp_sda, bp_scl};

  hic_sync2 #(.W(LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_lines),
    .q     (sync_lines)
  );

  hic_bus_watch #(.IDLE_CYCLES(IDLE_CYCLES)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (sync_lines),
    .clear    (~waiting),
    .stop_ok  (stop_ok),
    .idle_hit (idle_hit)
  );

  hic_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .enable    (enable),
    .stop_ok   (stop_ok),
    .idle_hit  (idle_hit),
    .waiting   (waiting),
    .linked    (linked)
  );

  // supply loss drops the link without waiting for an edge
  assign connect      = linked & supply_ok;
  assign ready        = connect;
  assign precharge_en = ~connect;
endmodule

// File: rtl/hic_checker.sv
module hic_checker (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic enable,
  input logic connect,
  input logic precharge_en,
  input logic ready
);
  p_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (!connect && !ready && precharge_en));

  p_lock_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !connect);

  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !connect);

  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connect) |-> ($past(enable) && $past(supply_ok)));

  p_fall_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(connect) |-> (!supply_ok || $past(!enable)));
endmodule

bind hotplug_connect_ctrl hic_checker u_hic_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .supply_ok    (supply_ok),
  .enable       (enable),
  .connect      (connect),
  .precharge_en (precharge_en),
  .ready        (ready)
);

// File: tb/hotplug_connect_ctrl_tb.sv
module hotplug_connect_ctrl_tb_top;
  localparam int unsigned N = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok, enable, bp_scl, bp_sda, cd_scl, cd_sda;
  logic connect, precharge_en, ready;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  hotplug_connect_ctrl #(.IDLE_CYCLES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
    .bp_scl(bp_scl), .bp_sda(bp_sda), .cd_scl(cd_scl), .cd_sda(cd_sda),
    .connect(connect), .precharge_en(precharge_en), .ready(ready)
  );

  function automatic bit exp_idle_join(int unsigned len);
    return len >= N;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic tick(input int unsigned n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic lines(input logic a, input logic b, input logic c, input logic d);
    bp_scl = a; bp_sda = b; cd_scl = c; cd_sda = d;
  endtask

  task automatic outs(input string tag, input logic c);
    check(tag, connect, c);
    check({tag, " ready"}, ready, c);
    check({tag, " precharge"}, precharge_en, ~c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; supply_ok = 1'b0; enable = 1'b0;
    lines(1'b0, 1'b0, 1'b0, 1'b0);
    tick(3);
    outs("R2 reset", 1'b0);
    rst_n = 1'b1;

    // R1: lockout ignores idle and STOP
    enable = 1'b1;
    lines(1'b1, 1'b0, 1'b1, 1'b1);
    tick(3);
    bp_sda = 1'b1;
    tick(3 * N);
    outs("R1 lockout", 1'b0);

    // R3: STOP while waiting
    lines(1'b0, 1'b0, 1'b1, 1'b1);
    supply_ok = 1'b1;
    tick(1);
    check("R1 first cycle after supply", connect, 1'b0);
    tick(3);
    bp_scl = 1'b1;
    tick(3);
    bp_sda = 1'b1;
    tick(1);
    tick(1);
    check("R3 stop early", connect, 1'b0);
    tick(1);
    outs("R3 stop join", 1'b1);
    check("R7 ready", ready, connect);

    // R9: supply loss drops at once
    supply_ok = 1'b0;
    #1;
    check("R9 immediate drop", connect, 1'b0);
    check("R9 precharge", precharge_en, 1'b1);
    tick(2);
    supply_ok = 1'b1;
    tick(N);
    check("R9 rewait early", connect, 1'b0);
    tick(1);
    check("R9 rewait join", connect, 1'b1);

    // R8: disable then re-enable
    enable = 1'b0;
    tick(1);
    outs("R8 disable", 1'b0);
    tick(3 * N);
    check("R10 idle while disabled", connect, 1'b0);
    lines(1'b1, 1'b0, 1'b1, 1'b1);
    tick(3);
    bp_sda = 1'b1;
    tick(5);
    check("R10 stop while disabled", connect, 1'b0);
    enable = 1'b1;
    tick(N);
    check("R8 reenable early", connect, 1'b0);
    tick(1);
    check("R8 reenable join", connect, 1'b1);

    // R4: STOP with card busy
    enable = 1'b0;
    lines(1'b1, 1'b0, 1'b1, 1'b0);
    tick(2);
    enable = 1'b1;
    tick(3);
    bp_sda = 1'b1;
    tick(6);
    check("R4 stop card busy", connect, 1'b0);

    // R5: exact idle lengths
    lines(1'b0, 1'b0, 1'b0, 1'b0);
    tick(3);
    lines(1'b1, 1'b1, 1'b1, 1'b1);
    tick(N - 1);
    lines(1'b0, 1'b0, 1'b0, 1'b0);
    tick(N + 4);
    check("R5 short idle", connect, 1'b0);
    lines(1'b1, 1'b1, 1'b1, 1'b1);
    tick(N + 1);
    check("R5 idle early", connect, 1'b0);
    tick(1);
    check("R5 idle join", connect, 1'b1);

    // R6: one low on a line restarts the count
    enable = 1'b0;
    lines(1'b0, 1'b0, 1'b0, 1'b0);
    tick(2);
    enable = 1'b1;
    tick(2);
    lines(1'b1, 1'b1, 1'b1, 1'b1);
    tick(N - 2);
    cd_scl = 1'b0;
    tick(1);
    cd_scl = 1'b1;
    tick(N + 1);
    check("R6 restart early", connect, 1'b0);
    tick(1);
    check("R6 restart join", connect, 1'b1);

    // R5: random idle pulses around the limit
    for (int i = 0; i < 16; i++) begin
      int unsigned len;
      len = N - 3 + ($urandom % 7);
      enable = 1'b0;
      lines(1'b0, 1'b0, 1'b0, 1'b0);
      tick(2);
      enable = 1'b1;
      tick(2 + ($urandom % 4));
      lines(1'b1, 1'b1, 1'b1, 1'b1);
      tick(len);
      lines(1'b0, 1'b0, 1'b0, 1'b0);
      tick(6);
      check($sformatf("R5 random len=%0d", len), connect, exp_idle_join(len));
      check("R7 random ready", ready, exp_idle_join(len));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule